// File: doc/BRIEF.md
# Branch Target Lookup Table

This block is a set-associative table that a fetch stage consults with an instruction's virtual address to learn whether that address holds a known branch and, if it does, where the branch goes. Each entry keeps a tag, a one-bit branch kind (conditional or unconditional) and the target address. A lookup presented on the probe port is answered by registered outputs in the following cycle. For an unconditional branch the stored target is delivered at once. For a conditional branch it is delivered only when a direction predictor outside this block says taken.

After a branch resolves, the pipeline presents it again on the resolve port. If the address is already in the table, the stored target is overwritten with the resolved one. Otherwise a way of the indexed set is filled with a new entry. Both actions take one cycle. The way to fill is always an empty way when the set has one. When every way is valid, an elaboration parameter picks the policy: a per-way most-recently-used bit scheme, or a free-running LFSR. The two ports work independently. A probe in the same cycle as a resolve write reads the table as it stood before that write.

Top module: `tgt_buffer`

## Requirements
- R1: Address bits [OFF_W+IDX_W-1:OFF_W] (bits [5:2] by default) select the set, and the bits above them form the tag. `lk_hit_o` is 1 in the cycle after a probe whose tag matches a valid entry of that set. An address that matches in only one of set or tag misses.
- R2: On a hit to an unconditional entry (`lk_cond_o` = 0), `lk_redirect_o` is 1 and `lk_target_o` carries the stored target, whatever the value of `lk_taken_i`.
- R3: On a hit to a conditional entry (`lk_cond_o` = 1), `lk_redirect_o` is 1 and `lk_target_o` carries the target only if `lk_taken_i` was 1. Otherwise `lk_redirect_o` is 0 and `lk_target_o` is 0.
- R4: After a cycle with no probe, or after a probe that misses, `lk_hit_o`, `lk_redirect_o` and `lk_cond_o` are 0 and `lk_target_o` is 0.
- R5: A resolve whose address misses writes a new valid entry holding the tag, `rs_cond_i` and `rs_target_i`. A later probe of that address hits with those values.
- R6: A resolve whose address hits overwrites only the stored target with `rs_target_i`. The entry's branch kind stays as first written, and no second entry is created.
- R7: A fill into a set that has an invalid way uses the lowest-numbered invalid way. As a result, WAYS distinct branches in one set all stay present.
- R8: With the MRU policy (the default), each way has a bit that is set by a probe hit or a resolve write to that way. If setting it would make every bit of the set 1, only the bits of the ways just touched remain set. When the set is full, a fill evicts the lowest-numbered way whose bit is 0.
- R9: A probe in the same cycle as a resolve write to the same set returns the contents from before that write.
- R10: Reset invalidates every entry, so every probe afterwards misses until new fills occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid_i | input | 1 | Probe request this cycle |
| lk_addr_i | input | ADDR_W | Virtual address being fetched |
| lk_taken_i | input | 1 | External direction prediction for a conditional branch |
| lk_hit_o | output | 1 | Probe of the previous cycle found an entry |
| lk_redirect_o | output | 1 | Fetch should go to `lk_target_o` |
| lk_cond_o | output | 1 | Hit entry is a conditional branch |
| lk_target_o | output | ADDR_W | Predicted target, 0 unless redirecting |
| rs_valid_i | input | 1 | Resolved branch presented this cycle |
| rs_addr_i | input | ADDR_W | Address of the resolved branch |
| rs_cond_i | input | 1 | Resolved branch is conditional (used on fill) |
| rs_target_i | input | ADDR_W | Resolved target address |

## Verification
The assertions assume that both address inputs carry known values whenever their valid strobes are high. They also assume that WAYS is a power of two, so that the LFSR variant always names an existing way. The bench drives every address and data input to defined values from reset onward, and it changes them only at the falling clock edge. Scenarios are chosen so that fill order, MRU bit history and same-cycle probe/resolve collisions each have one predictable outcome: the MRU case touches a specific way between two evictions, so the second victim differs from the one a round-robin or random policy would pick.

// File: rtl/tgt_buffer_pkg.sv
package tgt_buffer_pkg;

  typedef enum logic {
    REPL_RANDOM = 1'b0,
    REPL_MRU    = 1'b1
  } repl_e;

endpackage

// File: rtl/tgt_buffer_rst_sync.sv
module tgt_buffer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/tgt_buffer_lfsr.sv
module tgt_buffer_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400,
  parameter logic [W-1:0]   SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // A Galois LFSR seeded non-zero never reaches the all-zero lock-up state.
  a_lfsr_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/tgt_buffer_match.sv
module tgt_buffer_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAYS-1:0]            oh_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign oh_o[w] = vld_i[w] && (tag_i[w] == key_i);
  end

  assign hit_o = |oh_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oh_o[w]) begin
        way_o = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/tgt_buffer_victim.sv
module tgt_buffer_victim
  import tgt_buffer_pkg::*;
#(
  parameter int    SETS   = 16,
  parameter int    WAYS   = 4,
  parameter int    IDX_W  = 4,
  parameter int    WAY_W  = 2,
  parameter repl_e REPL   = REPL_MRU,
  parameter int    LFSR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  row_vld_i,
  input  logic [IDX_W-1:0] row_set_i,
  input  logic             ta_en_i,
  input  logic [IDX_W-1:0] ta_set_i,
  input  logic [WAY_W-1:0] ta_way_i,
  input  logic             tb_en_i,
  input  logic [IDX_W-1:0] tb_set_i,
  input  logic [WAY_W-1:0] tb_way_i,
  output logic [WAY_W-1:0] victim_o
);

  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] policy_way;

  // Lowest-numbered empty way wins over any policy choice.
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_vld_i[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  if (REPL == REPL_MRU) begin : g_mru
    logic [SETS-1:0][WAYS-1:0] mru_q;
    logic [SETS-1:0][WAYS-1:0] mru_d;
    logic [SETS-1:0]           mru_en;

    always_comb begin
      logic [WAYS-1:0] mask;
      logic [WAYS-1:0] merged;
      mru_d  = mru_q;
      mru_en = '0;
      for (int s = 0; s < SETS; s++) begin
        mask = '0;
        if (ta_en_i && (ta_set_i == IDX_W'(s))) mask[ta_way_i] = 1'b1;
        if (tb_en_i && (tb_set_i == IDX_W'(s))) mask[tb_way_i] = 1'b1;
        merged = mru_q[s] | mask;
        if (|mask) begin
          mru_en[s] = 1'b1;
          mru_d[s]  = (&merged) ? mask : merged;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mru_q <= '0;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (mru_en[s]) mru_q[s] <= mru_d[s];
        end
      end
    end

    always_comb begin
      policy_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!mru_q[row_set_i][w]) policy_way = WAY_W'(w);
      end
    end

    if (WAYS > 1) begin : g_chk
      // R8: the per-set MRU bits never all read 1, so a victim with bit 0 exists.
      a_r8_mru_headroom: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tb_en_i |-> !(&mru_q[row_set_i]));
    end
  end else begin : g_rand
    logic [LFSR_W-1:0] lfsr_state;

    tgt_buffer_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_W'(16'hB400)),
      .SEED (LFSR_W'(1))
    ) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .state_o (lfsr_state)
    );

    assign policy_way = WAY_W'(lfsr_state % LFSR_W'(WAYS));
  end

  assign victim_o = free_any ? free_way : policy_way;

  // R7: while the indexed set has an empty way, the chosen way is empty.
  a_r7_prefer_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_en_i && !(&row_vld_i)) |-> !row_vld_i[victim_o]);

endmodule

// File: rtl/tgt_buffer.sv
module tgt_buffer
  import tgt_buffer_pkg::*;
#(
  parameter int    ADDR_W = 32,
  parameter int    SETS   = 16,
  parameter int    WAYS   = 4,
  parameter int    OFF_W  = 2,
  parameter repl_e REPL   = REPL_MRU
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_taken_i,
  output logic              lk_hit_o,
  output logic              lk_redirect_o,
  output logic              lk_cond_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              rs_valid_i,
  input  logic [ADDR_W-1:0] rs_addr_i,
  input  logic              rs_cond_i,
  input  logic [ADDR_W-1:0] rs_target_i
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic rst_n;

  tgt_buffer_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // Table storage: valid bits are reset, payload is not.
  logic [SETS-1:0][WAYS-1:0]             vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0]             cond_q;
  logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tgt_q;

  // ---------------- probe side ----------------
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_oh;
  logic             lk_match;
  logic [WAY_W-1:0] lk_way;

  assign lk_set = lk_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];

  tgt_buffer_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
    .vld_i (vld_q[lk_set]),
    .tag_i (tag_q[lk_set]),
    .key_i (lk_tag),
    .oh_o  (lk_oh),
    .hit_o (lk_match),
    .way_o (lk_way)
  );

  logic              lk_hit_d;
  logic              lk_redir_d;
  logic              lk_cond_d;
  logic [ADDR_W-1:0] lk_tgt_d;

  always_comb begin
    lk_hit_d   = lk_valid_i && lk_match;
    lk_cond_d  = lk_hit_d && cond_q[lk_set][lk_way];
    lk_redir_d = lk_hit_d && (!cond_q[lk_set][lk_way] || lk_taken_i);
    lk_tgt_d   = lk_redir_d ? tgt_q[lk_set][lk_way] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit_o      <= 1'b0;
      lk_redirect_o <= 1'b0;
      lk_cond_o     <= 1'b0;
      lk_target_o   <= '0;
    end else begin
      lk_hit_o      <= lk_hit_d;
      lk_redirect_o <= lk_redir_d;
      lk_cond_o     <= lk_cond_d;
      lk_target_o   <= lk_tgt_d;
    end
  end

  // ---------------- resolve side ----------------
  logic [IDX_W-1:0] rs_set;
  logic [TAG_W-1:0] rs_tag;
  logic [WAYS-1:0]  rs_oh;
  logic             rs_match;
  logic [WAY_W-1:0] rs_way;
  logic [WAY_W-1:0] victim_way;

  assign rs_set = rs_addr_i[OFF_W +: IDX_W];
  assign rs_tag = rs_addr_i[ADDR_W-1 -: TAG_W];

  tgt_buffer_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_rs_match (
    .vld_i (vld_q[rs_set]),
    .tag_i (tag_q[rs_set]),
    .key_i (rs_tag),
    .oh_o  (rs_oh),
    .hit_o (rs_match),
    .way_o (rs_way)
  );

  logic             upd_en;
  logic             fill_en;
  logic [WAY_W-1:0] wr_way;

  always_comb begin
    upd_en  = rs_valid_i && rs_match;
    fill_en = rs_valid_i && !rs_match;
    wr_way  = rs_match ? rs_way : victim_way;
  end

  tgt_buffer_victim #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .REPL  (REPL)
  ) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .row_vld_i (vld_q[rs_set]),
    .row_set_i (rs_set),
    .ta_en_i   (lk_hit_d),
    .ta_set_i  (lk_set),
    .ta_way_i  (lk_way),
    .tb_en_i   (rs_valid_i),
    .tb_set_i  (rs_set),
    .tb_way_i  (wr_way),
    .victim_o  (victim_way)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[rs_set][victim_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rs_valid_i) begin
      tgt_q[rs_set][wr_way] <= rs_target_i;
    end
    if (fill_en) begin
      tag_q[rs_set][victim_way]  <= rs_tag;
      cond_q[rs_set][victim_way] <= rs_cond_i;
    end
  end

  // ---------------- assertions ----------------
  // R1: a probed set never holds two valid copies of one tag.
  a_r1_single_match: assert property (@(posedge clk_i) disable iff (!rst_n)
    lk_valid_i |-> $onehot0(lk_oh));

  // R4: no probe means quiet outputs in the next cycle.
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !lk_valid_i |=> (!lk_hit_o && !lk_redirect_o && lk_target_o == '0));

  // R3: a conditional entry never redirects without a taken prediction.
  a_r3_cond_gated: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lk_valid_i && !lk_taken_i) |=> !(lk_redirect_o && lk_cond_o));

  // R5: a fill leaves a valid entry with the resolved tag in the chosen way.
  a_r5_fill_lands: assert property (@(posedge clk_i) disable iff (!rst_n)
    fill_en |=> (vld_q[$past(rs_set)][$past(victim_way)] &&
                 tag_q[$past(rs_set)][$past(victim_way)] == $past(rs_tag)));

  // R6: an update keeps the entry valid and stores the new target.
  a_r6_update_lands: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd_en |=> (vld_q[$past(rs_set)][$past(rs_way)] &&
                tgt_q[$past(rs_set)][$past(rs_way)] == $past(rs_target_i)));

endmodule

// File: tb/tgt_buffer_bench.sv
module tgt_buffer_bench;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_valid;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_taken;
  logic              lk_hit;
  logic              lk_redirect;
  logic              lk_cond;
  logic [ADDR_W-1:0] lk_target;
  logic              rs_valid;
  logic [ADDR_W-1:0] rs_addr;
  logic              rs_cond;
  logic [ADDR_W-1:0] rs_target;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  tgt_buffer u_tgt_buffer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .lk_valid_i    (lk_valid),
    .lk_addr_i     (lk_addr),
    .lk_taken_i    (lk_taken),
    .lk_hit_o      (lk_hit),
    .lk_redirect_o (lk_redirect),
    .lk_cond_o     (lk_cond),
    .lk_target_o   (lk_target),
    .rs_valid_i    (rs_valid),
    .rs_addr_i     (rs_addr),
    .rs_cond_i     (rs_cond),
    .rs_target_i   (rs_target)
  );

  // Set in bits [5:2], tag in bits [31:6].
  function automatic logic [31:0] mk(input logic [25:0] tag, input logic [3:0] set);
    return {tag, set, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic tk);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_taken = tk;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] a, input logic c, input logic [31:0] t);
    @(negedge clk);
    rs_valid = 1'b1; rs_addr = a; rs_cond = c; rs_target = t;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic expect_probe(input string req, input logic [31:0] a, input logic tk,
                              input logic h, input logic r, input logic c,
                              input logic [31:0] t);
    probe(a, tk);
    check({req, " hit"}, 32'(lk_hit), 32'(h));
    check({req, " redirect"}, 32'(lk_redirect), 32'(r));
    check({req, " cond"}, 32'(lk_cond), 32'(c));
    check({req, " target"}, lk_target, t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R4 reset hit", 32'(lk_hit), 32'd0);
    check("R4 reset target", lk_target, 32'd0);
    expect_probe("R10 empty table", mk(26'h5, 4'd1), 1'b1, 0, 0, 0, 32'd0);
  endtask

  task automatic t_uncond();
    resolve(mk(26'h5, 4'd1), 1'b0, 32'h0000_1230);
    expect_probe("R5/R2 uncond not-taken", mk(26'h5, 4'd1), 1'b0, 1, 1, 0, 32'h0000_1230);
    expect_probe("R2 uncond taken", mk(26'h5, 4'd1), 1'b1, 1, 1, 0, 32'h0000_1230);
  endtask

  task automatic t_cond();
    resolve(mk(26'h77, 4'd3), 1'b1, 32'h0000_4440);
    expect_probe("R3 cond not-taken", mk(26'h77, 4'd3), 1'b0, 1, 0, 1, 32'd0);
    expect_probe("R3 cond taken", mk(26'h77, 4'd3), 1'b1, 1, 1, 1, 32'h0000_4440);
  endtask

  task automatic t_update();
    resolve(mk(26'h77, 4'd3), 1'b0, 32'h0000_9990);
    expect_probe("R6 new target", mk(26'h77, 4'd3), 1'b1, 1, 1, 1, 32'h0000_9990);
    expect_probe("R6 kind kept", mk(26'h77, 4'd3), 1'b0, 1, 0, 1, 32'd0);
  endtask

  task automatic t_index();
    expect_probe("R1 other tag", mk(26'h6, 4'd1), 1'b1, 0, 0, 0, 32'd0);
    expect_probe("R1 other set", mk(26'h5, 4'd2), 1'b1, 0, 0, 0, 32'd0);
    expect_probe("R4 idle after miss", mk(26'h5, 4'd1), 1'b0, 1, 1, 0, 32'h0000_1230);
    @(negedge clk);
    check("R4 no probe", 32'(lk_hit), 32'd0);
  endtask

  task automatic t_fill_ways();
    for (int i = 0; i < 4; i++) resolve(mk(26'h100 + 26'(i), 4'd5), 1'b0, 32'h100 * (i + 1));
    for (int i = 0; i < 4; i++)
      expect_probe("R7 all ways kept", mk(26'h100 + 26'(i), 4'd5), 1'b0, 1, 1, 0, 32'h100 * (i + 1));
  endtask

  task automatic t_mru();
    // Fills A0..A3 occupy ways 0..3; A4 evicts way 0; probing A1 marks way 1; A5 evicts way 2.
    for (int i = 0; i < 5; i++) resolve(mk(26'h200 + 26'(i), 4'd7), 1'b0, 32'h2000 + 32'(i));
    probe(mk(26'h201, 4'd7), 1'b0);
    resolve(mk(26'h205, 4'd7), 1'b0, 32'h2005);
    expect_probe("R8 A0 evicted", mk(26'h200, 4'd7), 1'b0, 0, 0, 0, 32'd0);
    expect_probe("R8 A2 evicted", mk(26'h202, 4'd7), 1'b0, 0, 0, 0, 32'd0);
    expect_probe("R8 A1 kept", mk(26'h201, 4'd7), 1'b0, 1, 1, 0, 32'h2001);
    expect_probe("R8 A3 kept", mk(26'h203, 4'd7), 1'b0, 1, 1, 0, 32'h2003);
    expect_probe("R8 A4 kept", mk(26'h204, 4'd7), 1'b0, 1, 1, 0, 32'h2004);
    expect_probe("R8 A5 kept", mk(26'h205, 4'd7), 1'b0, 1, 1, 0, 32'h2005);
  endtask

  task automatic t_same_cycle();
    resolve(mk(26'h30, 4'd9), 1'b0, 32'h0000_A000);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(26'h30, 4'd9); lk_taken = 1'b0;
    rs_valid = 1'b1; rs_addr = mk(26'h30, 4'd9); rs_cond = 1'b0; rs_target = 32'h0000_B000;
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    check("R9 old target", lk_target, 32'h0000_A000);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(26'h31, 4'd9);
    rs_valid = 1'b1; rs_addr = mk(26'h31, 4'd9); rs_target = 32'h0000_C000;
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    check("R9 fill not seen", 32'(lk_hit), 32'd0);
    expect_probe("R9 update visible", mk(26'h30, 4'd9), 1'b0, 1, 1, 0, 32'h0000_B000);
    expect_probe("R9 fill visible", mk(26'h31, 4'd9), 1'b0, 1, 1, 0, 32'h0000_C000);
  endtask

  task automatic t_reset_clears();
    do_reset();
    expect_probe("R10 cleared", mk(26'h5, 4'd1), 1'b0, 0, 0, 0, 32'd0);
    expect_probe("R10 cleared set7", mk(26'h204, 4'd7), 1'b0, 0, 0, 0, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_addr = '0; lk_taken = 1'b0;
    rs_valid = 1'b0; rs_addr = '0; rs_cond = 1'b0; rs_target = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_uncond();
    t_cond();
    t_update();
    t_index();
    t_fill_ways();
    t_mru();
    t_same_cycle();
    t_reset_clears();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule